// File: doc/BRIEF.md
# Multi-Channel Edge-Positioned PWM Generator

This block produces sixteen pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock into steps, and a step counter counts steps from zero up to a programmed terminal value. Every channel uses the same period. Each channel stores two step positions: the step at which its output goes high and the step at which it goes low. When the low position comes before the high position, the channel produces an inverted waveform.

Software programs the block through a byte-addressed port with 8-bit data and a write strobe. The read port is combinational. A build-time mask picks which channels buffer their edge positions. On a buffered channel, new positions are only staged when written. They move into the live comparators at the end of a period, and only after a global update flag has been set. A channel outside the mask uses a written value on the next cycle. Disabled channels hold their output low.

Register map: 0x00 prescale, 0x01 period, 0x02 enables for channels 0–7, 0x03 enables for channels 8–15, 0x04 update flag, 0x10+c rising position of channel c, 0x20+c falling position of channel c.

Top module: `edgepwm_top`

## Requirements
- R1: One output period lasts exactly (period+1)×(prescale+1) clock cycles, where prescale is the value at address 0x00 and period is the value at address 0x01.
- R2: When rise < fall (rise at 0x10+c, fall at 0x20+c, both ≤ period), channel c is high for (fall−rise)×(prescale+1) cycles in each period.
- R3: When fall < rise, channel c is inverted. It is low for (rise−fall)×(prescale+1) cycles in each period and high for the remainder.
- R4: When rise equals fall, channel c stays low.
- R5: The enable for channel c is bit c of address 0x02 for c<8, and bit c−8 of address 0x03 for c≥8. Both registers read back as written. A channel whose enable is 0 drives low within two cycles of the write.
- R6: On a channel outside the buffer mask (default mask 16'hFF00, so channels 0–7), a new rise or fall value changes the waveform from the next period on, with no update flag.
- R7: On a channel inside the buffer mask, writes to rise or fall leave the waveform unchanged until the update flag is set. After the flag is set, the new values take effect at the next period end.
- R8: Writing a value with bit 0 set to address 0x04 sets the update flag. Address 0x04 reads 1 until the next period end and 0 afterwards.
- R9: After reset, every register reads 0 and every output is low.
- R10: Addresses 0x00, 0x01, 0x10+c and 0x20+c read back the last value written, including staged values on buffered channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pwm_out | output | 16 | Channel outputs |

## Verification
The assertions assume that every write is a single-cycle strobe with a stable address. They also assume that the prescale and period registers stay fixed while the counters are being compared against them. The stimulus meets both assumptions by changing the time base only between measurements and by leaving several periods for settling before any sample. The edge positions in the stimulus never exceed the period, so every programmed transition actually occurs. The update flag is never written in the same cycle as a period end.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;
    // Register byte addresses; the upper enable byte sits at A_EN_LO + 1.
    localparam int A_PRESCALE = 0;
    localparam int A_PERIOD   = 1;
    localparam int A_EN_LO    = 2;
    localparam int A_SYNC     = 4;
    localparam int A_POS_BASE = 16;
    localparam int A_NEG_BASE = 32;
endpackage

// File: rtl/edgepwm_timebase.sv
module edgepwm_timebase #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] prescale,
    input  logic [DW-1:0] period,
    output logic          tick,
    output logic          boundary,
    output logic [DW-1:0] step
);
    typedef struct packed {
        logic [DW-1:0] pre;
        logic [DW-1:0] stp;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      tick_c;

    always_comb begin
        s_d    = s_q;
        tick_c = (s_q.pre >= prescale);
        if (tick_c) begin
            s_d.pre = '0;
            if (s_q.stp >= period) s_d.stp = '0;
            else                   s_d.stp = s_q.stp + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick     = tick_c;
    assign boundary = tick_c && (s_q.stp >= period);
    assign step     = s_q.stp;

    // R1
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.stp >= period) |=> (s_q.stp == '0));

    // R1
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.stp));
endmodule

// File: rtl/edgepwm_channel.sv
module edgepwm_channel #(
    parameter int DW       = 8,
    parameter bit SHADOWED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          boundary,
    input  logic          sync_pend,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] pos_stage,
    input  logic [DW-1:0] neg_stage,
    output logic          out
);
    typedef struct packed {
        logic [DW-1:0] pos;
        logic [DW-1:0] neg;
    } edges_t;

    typedef struct packed {
        logic lvl;
    } ch_state_t;

    edges_t act;

    generate
        if (SHADOWED) begin : g_shadow
            edges_t act_d, act_q;

            always_comb begin
                act_d = act_q;
                if (boundary && sync_pend) begin
                    act_d.pos = pos_stage;
                    act_d.neg = neg_stage;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) act_q <= '0;
                else        act_q <= act_d;
            end

            assign act = act_q;

            // R7
            shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(boundary && sync_pend) |=> $stable(act_q));
        end else begin : g_direct
            logic unused_direct;
            assign unused_direct = boundary ^ sync_pend;
            assign act = {pos_stage, neg_stage};
        end
    endgenerate

    ch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.lvl = 1'b0;
        end else if (tick) begin
            if (step == act.neg)      s_d.lvl = 1'b0;
            else if (step == act.pos) s_d.lvl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out = s_q.lvl;

    // R5
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out);

    // R4
    fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && step == act.neg) |=> !out);

    // R2
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && step == act.pos && step != act.neg) |=> out);
endmodule

// File: rtl/edgepwm_regfile.sv
module edgepwm_regfile
    import edgepwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DW     = 8,
    parameter int AW     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic                       bus_we,
    input  logic                       boundary,
    output logic [DW-1:0]              bus_rdata,
    output logic [DW-1:0]              prescale,
    output logic [DW-1:0]              period,
    output logic [NUM_CH-1:0]          en,
    output logic                       sync_pend,
    output logic [NUM_CH-1:0][DW-1:0]  pos,
    output logic [NUM_CH-1:0][DW-1:0]  neg
);
    localparam int EN_BITS = 8;

    typedef struct packed {
        logic [DW-1:0]             prescale;
        logic [DW-1:0]             period;
        logic [NUM_CH-1:0]         en;
        logic                      pend;
        logic [NUM_CH-1:0][DW-1:0] pos;
        logic [NUM_CH-1:0][DW-1:0] neg;
    } regs_t;

    regs_t s_d, s_q;
    logic  sync_wr;

    assign sync_wr = bus_we && (bus_addr == AW'(A_SYNC)) && bus_wdata[0];

    always_comb begin
        s_d = s_q;
        if (bus_we) begin
            if (bus_addr == AW'(A_PRESCALE)) s_d.prescale = bus_wdata;
            if (bus_addr == AW'(A_PERIOD))   s_d.period   = bus_wdata;
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == AW'(A_EN_LO + c / EN_BITS))
                    s_d.en[c] = bus_wdata[3'(c % EN_BITS)];
                if (bus_addr == AW'(A_POS_BASE + c)) s_d.pos[c] = bus_wdata;
                if (bus_addr == AW'(A_NEG_BASE + c)) s_d.neg[c] = bus_wdata;
            end
        end
        if (sync_wr)       s_d.pend = 1'b1;
        else if (boundary) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_PRESCALE)) bus_rdata = s_q.prescale;
        if (bus_addr == AW'(A_PERIOD))   bus_rdata = s_q.period;
        if (bus_addr == AW'(A_SYNC))     bus_rdata[0] = s_q.pend;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == AW'(A_EN_LO + c / EN_BITS))
                bus_rdata[3'(c % EN_BITS)] = s_q.en[c];
            if (bus_addr == AW'(A_POS_BASE + c)) bus_rdata = s_q.pos[c];
            if (bus_addr == AW'(A_NEG_BASE + c)) bus_rdata = s_q.neg[c];
        end
    end

    assign prescale  = s_q.prescale;
    assign period    = s_q.period;
    assign en        = s_q.en;
    assign sync_pend = s_q.pend;
    assign pos       = s_q.pos;
    assign neg       = s_q.neg;

    // R8
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_wr |=> sync_pend);

    // R8
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !sync_wr) |=> !sync_pend);
endmodule

// File: rtl/edgepwm_top.sv
module edgepwm_top #(
    parameter int                 NUM_CH      = 16,
    parameter int                 DW          = 8,
    parameter int                 AW          = 6,
    parameter logic [NUM_CH-1:0]  SHADOW_MASK = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [DW-1:0]             prescale, period, step;
    logic [NUM_CH-1:0]         en;
    logic                      sync_pend, tick, boundary;
    logic [NUM_CH-1:0][DW-1:0] pos, neg;

    edgepwm_regfile #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .boundary(boundary), .bus_rdata(bus_rdata),
        .prescale(prescale), .period(period), .en(en),
        .sync_pend(sync_pend), .pos(pos), .neg(neg)
    );

    edgepwm_timebase #(.DW(DW)) tb_i (
        .clk(clk), .rst_n(rst_n),
        .prescale(prescale), .period(period),
        .tick(tick), .boundary(boundary), .step(step)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            edgepwm_channel #(.DW(DW), .SHADOWED(SHADOW_MASK[c])) ch_i (
                .clk(clk), .rst_n(rst_n),
                .en(en[c]), .tick(tick), .boundary(boundary),
                .sync_pend(sync_pend), .step(step),
                .pos_stage(pos[c]), .neg_stage(neg[c]),
                .out(pwm_out[c])
            );
        end
    endgenerate
endmodule

// File: tb/edgepwm_top_tb_top.sv
module edgepwm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    edgepwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {prescale, period, rise, fall} for channel 3 (unbuffered)
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'd9,  8'd2,  8'd6},
        {8'd1, 8'd7,  8'd1,  8'd5},
        {8'd2, 8'd4,  8'd0,  8'd3},
        {8'd0, 8'd15, 8'd10, 8'd3},
        {8'd3, 8'd5,  8'd4,  8'd1},
        {8'd0, 8'd3,  8'd0,  8'd3}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 6'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int ch, output int plen, output int hcnt);
        logic prev;
        bit   found;
        plen = -1; hcnt = -1; found = 1'b0;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int n = 0; n < 4000 && !found; n++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) found = 1'b1;
            prev = pwm_out[ch];
        end
        if (!found) return;
        plen = 0; hcnt = 0; prev = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            if (pwm_out[ch]) hcnt++;
            plen++;
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic high_over(input int ch, input int n, output int hcnt);
        hcnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hcnt++;
        end
    endtask

    function automatic int exp_high(int ps, int per, int r, int f);
        if (r < f) return (f - r) * (ps + 1);
        return (per + 1 - (r - f)) * (ps + 1);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v, pl, hc;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9 reset state
        chk("R9 outputs", int'(pwm_out), 0);
        for (int a = 0; a < 5; a++) begin
            rd(a, v); chk("R9 reg", v, 0);
        end
        rd(16 + 9, v); chk("R9 rise9", v, 0);
        rd(32 + 3, v); chk("R9 fall3", v, 0);

        // R5 enable channel 3 and channel 9, read back
        wr(2, 8'h08);
        wr(3, 8'h02);
        rd(2, v); chk("R5 en lo", v, 8'h08);
        rd(3, v); chk("R5 en hi", v, 8'h02);

        // Table walk on channel 3: R1 period, R2/R3 high time
        for (int i = 0; i < 6; i++) begin
            int ps, per, r, f;
            ps = int'(VEC[i][31:24]); per = int'(VEC[i][23:16]);
            r = int'(VEC[i][15:8]);   f = int'(VEC[i][7:0]);
            wr(0, ps); wr(1, per); wr(16 + 3, r); wr(32 + 3, f);
            idle(3 * (per + 1) * (ps + 1) + 4);
            measure(3, pl, hc);
            chk("R1 period", pl, (per + 1) * (ps + 1));
            if (r < f) chk("R2 high", hc, exp_high(ps, per, r, f));
            else       chk("R3 inverted high", hc, exp_high(ps, per, r, f));
        end

        // R10 readback of last table values
        rd(0, v); chk("R10 prescale", v, 0);
        rd(1, v); chk("R10 period", v, 3);
        rd(16 + 3, v); chk("R10 rise3", v, 0);
        rd(32 + 3, v); chk("R10 fall3", v, 3);

        // R6 unbuffered channel changes without update flag
        wr(0, 0); wr(1, 9); wr(16 + 3, 2); wr(32 + 3, 6);
        idle(25);
        measure(3, pl, hc); chk("R6 before", hc, 4);
        wr(32 + 3, 8);
        idle(25);
        measure(3, pl, hc); chk("R6 after", hc, 6);

        // R4 equal edges
        wr(32 + 3, 2);
        idle(25);
        high_over(3, 40, hc); chk("R4 equal edges", hc, 0);

        // R5 disable drives low
        wr(32 + 3, 7);
        idle(25);
        measure(3, pl, hc); chk("R5 running", hc, 5);
        wr(2, 0);
        idle(2);
        high_over(3, 40, hc); chk("R5 disabled low", hc, 0);

        // R7/R8 buffered channel 9
        wr(16 + 9, 1); wr(32 + 9, 4);
        idle(30);
        high_over(9, 30, hc); chk("R7 staged not live", hc, 0);
        rd(4, v); chk("R8 flag idle", v, 0);
        rd(16 + 9, v); chk("R10 staged rise9", v, 1);
        wr(4, 1);
        rd(4, v); chk("R8 flag set", v, 1);
        idle(12);
        rd(4, v); chk("R8 flag cleared", v, 0);
        measure(9, pl, hc);
        chk("R7 loaded period", pl, 10);
        chk("R7 loaded high", hc, 3);
        wr(32 + 9, 7);
        idle(25);
        measure(9, pl, hc); chk("R7 held old", hc, 3);
        wr(4, 1);
        idle(25);
        measure(9, pl, hc); chk("R7 new after update", hc, 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule